// File: doc/BRIEF.md
# Prescaled 8-bit Timer/Counter

This block is an 8-bit up-counter with a small register set reached over a simple single-cycle bus. It counts one of two event sources:

- a tick derived from the system clock, one every `TICK_DIV` cycles;
- edges on an external clock pin. A configuration bit picks whether rising or falling edges count.

The pin passes through a two-flop synchroniser before any edge is detected.

Between the chosen source and the counter sits a binary prescaler. A 3-bit rate code divides the event stream by 2^(code+1), which covers ratios from 1:2 to 1:256. A bypass bit routes events straight to the counter instead.

When the counter rolls over from 0xFF to 0x00, an overflow flag is set. The flag, ANDed with an enable bit, drives the interrupt output. Whenever software loads the counter, the prescaler is cleared and the next two count events are swallowed.

The count gate is a three-state machine:
- `ST_RUN` passes events to the counter.
- `ST_SKIP_A` drops an event and moves to `ST_SKIP_B`.
- `ST_SKIP_B` drops an event and returns to `ST_RUN`.
- A counter load forces the machine to `ST_SKIP_A` from any state.

Top module: `pt8_timer`

## Requirements
- R1: After reset the configuration reads 0x3F (external source, falling edge, prescaler bypassed, rate code 7), the counter reads 0x00, the control register reads 0x00 and `irq` is low.
- R2: Address 0 reads and loads the counter. Address 1 holds the configuration in bits 5:0: bit 5 is source select, bit 4 is edge select, bit 3 is bypass and bits 2:0 are the rate code. Bits 7:6 read 0 and their written values are dropped. Address 2 holds the flag in bit 0 and the enable in bit 1. Address 3 reads 0.
- R3: With bit 5 clear, the counter source is an internal tick, one every 4 clock cycles; the external pin is ignored.
- R4: With bit 5 set, external pin edges count. Bit 4 clear selects low-to-high edges and bit 4 set selects high-to-low edges.
- R5: With bit 3 set, every source event goes to the counter unscaled.
- R6: With bit 3 clear, one counter event is produced per 2^(code+1) source events.
- R7: A write to address 0 loads the written value and clears the prescaler. The next two counter events after the write do not increment.
- R8: An increment from 0xFF to 0x00 sets the flag. A software write to bit 0 sets or clears the flag, and a hardware set wins over a write in the same cycle.
- R9: `irq` is high exactly when both the flag and the enable bit are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk_pin | input | 1 | External count pin, asynchronous |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Overflow interrupt request |

## Verification
The assertions assume three things about the inputs:
- each bus write lasts exactly one cycle;
- the external pin holds every level for at least two clock cycles, so the synchroniser sees each transition once;
- reset is applied before any bus activity.

The bench meets these by driving all inputs at the falling clock edge, holding each pin level for three cycles, and pulsing the write strobe for a single cycle per access. Exact expected counts rely on two facts: the prescaler and the skip gate are both reset by the counter load, and the internal tick window is sampled after a whole number of tick periods.

// File: rtl/pt8_pkg.sv
package pt8_pkg;

    localparam int RATE_W = 3;
    localparam int PS_W   = 1 << RATE_W;
    localparam int CFG_W  = RATE_W + 3;

    localparam logic [1:0] A_COUNT = 2'd0;
    localparam logic [1:0] A_CFG   = 2'd1;
    localparam logic [1:0] A_CTRL  = 2'd2;

    typedef struct packed {
        logic              ext_sel;
        logic              fall_edge;
        logic              bypass;
        logic [RATE_W-1:0] rate;
    } pt8_cfg_t;

    localparam pt8_cfg_t CFG_RESET = '{ext_sel: 1'b1, fall_edge: 1'b1,
                                       bypass: 1'b1, rate: '1};

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_SKIP_A = 2'd1,
        ST_SKIP_B = 2'd2
    } pt8_gate_e;

endpackage

// File: rtl/pt8_event_src.sv
module pt8_event_src #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic ext_sel,
    input  logic fall_edge,
    output logic src_evt
);

    logic sync_a, sync_b, sync_c;
    logic edge_hit;
    logic tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_a <= 1'b0;
            sync_b <= 1'b0;
            sync_c <= 1'b0;
        end else begin
            sync_a <= pin;
            sync_b <= sync_a;
            sync_c <= sync_b;
        end
    end

    always_comb begin
        if (fall_edge) edge_hit = sync_c & ~sync_b;
        else           edge_hit = sync_b & ~sync_c;
    end

    generate
        if (TICK_DIV > 1) begin : g_div
            localparam int DIV_W = $clog2(TICK_DIV);
            logic [DIV_W-1:0] div_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                          div_q <= '0;
                else if (div_q == DIV_W'(TICK_DIV-1)) div_q <= '0;
                else                                 div_q <= div_q + 1'b1;
            end
            assign tick = (div_q == DIV_W'(TICK_DIV-1));
        end else begin : g_nodiv
            assign tick = 1'b1;
        end
    endgenerate

    assign src_evt = ext_sel ? edge_hit : tick;

endmodule

// File: rtl/pt8_prescaler.sv
module pt8_prescaler
    import pt8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              bypass,
    input  logic [RATE_W-1:0] rate,
    input  logic              src_evt,
    output logic              cnt_evt
);

    logic [PS_W-1:0] ps_q;
    logic [PS_W:0]   span;
    logic [PS_W-1:0] mask;
    logic            carry;

    always_comb begin
        span  = (PS_W+1)'(2) << rate;
        mask  = PS_W'(span - 1'b1);
        carry = src_evt && ((ps_q | ~mask) == '1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  ps_q <= '0;
        else if (clear)              ps_q <= '0;
        else if (src_evt && !bypass) ps_q <= ps_q + 1'b1;
    end

    assign cnt_evt = bypass ? src_evt : carry;

endmodule

// File: rtl/pt8_counter.sv
module pt8_counter
    import pt8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             flag_wr,
    input  logic             flag_wval,
    output logic [CNT_W-1:0] count,
    output logic             inc,
    output logic             flag
);

    pt8_gate_e state_q, state_d;
    logic      wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = ST_SKIP_A;
        end else begin
            unique case (state_q)
                ST_RUN:    state_d = ST_RUN;
                ST_SKIP_A: if (evt) state_d = ST_SKIP_B;
                ST_SKIP_B: if (evt) state_d = ST_RUN;
                default:   state_d = ST_RUN;
            endcase
        end
    end

    always_comb begin
        inc  = 1'b0;
        unique case (state_q)
            ST_RUN:    inc = evt && !load;
            ST_SKIP_A: inc = 1'b0;
            ST_SKIP_B: inc = 1'b0;
            default:   inc = 1'b0;
        endcase
        wrap = inc && (count == '1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   count <= '0;
        else if (load) count <= load_val;
        else if (inc)  count <= count + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag <= 1'b0;
        else if (wrap)    flag <= 1'b1;
        else if (flag_wr) flag <= flag_wval;
    end

endmodule

// File: rtl/pt8_timer.sv
module pt8_timer
    import pt8_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int TICK_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_clk_pin,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             irq
);

    pt8_cfg_t         cfg_q;
    logic             en_q;
    logic             flag_q;
    logic             src_evt;
    logic             cnt_evt;
    logic             cnt_inc;
    logic [CNT_W-1:0] cnt_val;
    logic             wr_count, wr_cfg, wr_ctrl;

    assign wr_count = bus_wr && (bus_addr == A_COUNT);
    assign wr_cfg   = bus_wr && (bus_addr == A_CFG);
    assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
            en_q  <= 1'b0;
        end else begin
            if (wr_cfg)  cfg_q <= pt8_cfg_t'(bus_wdata[CFG_W-1:0]);
            if (wr_ctrl) en_q  <= bus_wdata[1];
        end
    end

    pt8_event_src #(.TICK_DIV(TICK_DIV)) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin       (ext_clk_pin),
        .ext_sel   (cfg_q.ext_sel),
        .fall_edge (cfg_q.fall_edge),
        .src_evt   (src_evt)
    );

    pt8_prescaler u_ps (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (wr_count),
        .bypass  (cfg_q.bypass),
        .rate    (cfg_q.rate),
        .src_evt (src_evt),
        .cnt_evt (cnt_evt)
    );

    pt8_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (cnt_evt),
        .load      (wr_count),
        .load_val  (bus_wdata),
        .flag_wr   (wr_ctrl),
        .flag_wval (bus_wdata[0]),
        .count     (cnt_val),
        .inc       (cnt_inc),
        .flag      (flag_q)
    );

    always_comb begin
        unique case (bus_addr)
            A_COUNT: bus_rdata = cnt_val;
            A_CFG:   bus_rdata = CNT_W'(cfg_q);
            A_CTRL:  bus_rdata = CNT_W'({en_q, flag_q});
            default: bus_rdata = '0;
        endcase
    end

    assign irq = flag_q & en_q;

endmodule

// File: rtl/pt8_timer_checker.sv
module pt8_timer_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic [CNT_W-1:0] bus_wdata,
    input logic             irq,
    input logic             cnt_inc,
    input logic [CNT_W-1:0] cnt_val,
    input logic             flag_q,
    input logic             en_q
);

    logic wr_cnt;
    assign wr_cnt = bus_wr && (bus_addr == 2'd0);

    // R7: load takes the written value
    assert_load_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (cnt_val == $past(bus_wdata)));

    // R7: the cycle after a load never increments
    assert_load_inhibit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> !cnt_inc);

    // R2: counter only moves on a load or an increment
    assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cnt && !cnt_inc) |=> $stable(cnt_val));

    // R8: a wrap always leaves the flag set, whatever software writes
    assert_wrap_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_inc && (cnt_val == '1)) |=> flag_q);

    // R9: no request while the enable is clear
    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !irq);

endmodule

bind pt8_timer pt8_timer_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .cnt_inc   (cnt_inc),
    .cnt_val   (cnt_val),
    .flag_q    (flag_q),
    .en_q      (en_q)
);

// File: tb/pt8_timer_bench.sv
module pt8_timer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pt8_timer u_pt8_timer (
        .clk(clk), .rst_n(rst_n), .ext_clk_pin(pin), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    typedef struct packed {
        logic [7:0]  cfg;
        logic [7:0]  start;
        logic [15:0] pulses;
        logic [7:0]  exp_cnt;
        logic        exp_flag;
    } vec_t;

    // cfg: bit5 external, bit4 falling, bit3 bypass, bits2:0 rate code
    localparam vec_t VECS [8] = '{
        '{8'h38, 8'h10, 16'd5,   8'h13, 1'b0},  // R4 R5 falling, bypass
        '{8'h28, 8'h00, 16'd10,  8'h08, 1'b0},  // R4 R5 rising, bypass
        '{8'h20, 8'h00, 16'd10,  8'h03, 1'b0},  // R6 1:2
        '{8'h21, 8'h40, 16'd20,  8'h43, 1'b0},  // R6 1:4
        '{8'h33, 8'h00, 16'd64,  8'h02, 1'b0},  // R6 1:16 falling
        '{8'h28, 8'hFE, 16'd5,   8'h01, 1'b1},  // R8 wrap, bypass
        '{8'h22, 8'hFF, 16'd24,  8'h00, 1'b1},  // R8 wrap, 1:8
        '{8'h27, 8'h00, 16'd768, 8'h01, 1'b0}   // R6 1:256
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse(input bit fall);
        pin = ~fall;
        repeat (3) @(negedge clk);
        pin = fall;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd1, v); check("R1 cfg", v, 8'h3F);
        rd(2'd0, v); check("R1 count", v, 8'h00);
        rd(2'd2, v); check("R1 ctrl", v, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);

        // vector table walk
        for (int i = 0; i < 8; i++) begin
            bit fall;
            fall = VECS[i].cfg[4];
            wr(2'd2, 8'h00);
            wr(2'd1, VECS[i].cfg);
            pin = fall;
            repeat (6) @(negedge clk);
            wr(2'd0, VECS[i].start);
            for (int p = 0; p < int'(VECS[i].pulses); p++) pulse(fall);
            repeat (4) @(negedge clk);
            rd(2'd0, v); check("R4/R5/R6/R7 count", v, VECS[i].exp_cnt);
            rd(2'd2, v); check("R8 flag", {7'd0, v[0]}, {7'd0, VECS[i].exp_flag});
        end

        // R3 internal tick, bypass; pin toggling is ignored
        wr(2'd1, 8'h08);
        wr(2'd0, 8'h00);
        for (int k = 0; k < 24; k++) begin
            @(posedge clk);
            pin = k[1];
        end
        @(negedge clk);
        rd(2'd0, v); check("R3 internal bypass", v, 8'd4);

        wr(2'd0, 8'h00);
        repeat (4 * (10 + 2)) @(posedge clk);
        @(negedge clk);
        check("R3 R7 internal exact", bus_rdata, 8'd10);

        // R6 internal with 1:2
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h00);
        repeat (8 * (5 + 2)) @(posedge clk);
        @(negedge clk);
        check("R6 internal 1:2", bus_rdata, 8'd5);

        // R2 register map
        wr(2'd1, 8'hE7);
        rd(2'd1, v); check("R2 cfg upper bits", v, 8'h27);
        rd(2'd3, v); check("R2 addr3", v, 8'h00);

        // R9 interrupt gating
        wr(2'd1, 8'h28);
        pin = 1'b0;
        repeat (6) @(negedge clk);
        wr(2'd2, 8'h02);
        #1 check("R9 enable only", {7'd0, irq}, 8'h00);
        wr(2'd0, 8'hFF);
        for (int p = 0; p < 3; p++) pulse(1'b0);
        repeat (4) @(negedge clk);
        check("R8 R9 wrap irq", {7'd0, irq}, 8'h01);
        wr(2'd2, 8'h01);
        #1 check("R9 flag no enable", {7'd0, irq}, 8'h00);
        rd(2'd2, v); check("R8 flag written", v, 8'h01);
        wr(2'd2, 8'h03);
        #1 check("R9 both set", {7'd0, irq}, 8'h01);
        wr(2'd2, 8'h02);
        #1 check("R8 R9 flag cleared", {7'd0, irq}, 8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule